// File: doc/BRIEF.md
# I2C Receive Byte Queue with First-Byte Marker

This block holds the bytes an I2C controller receives until software reads them through a register port. Each stored byte carries one marker bit. The marker is set on the first data byte that follows an address phase, whether the controller is the master receiver or the slave receiver. The protocol engine pushes each received byte with `rx_valid`. It pulses `addr_done` when an address phase completes, and that pulse arms the marker for the next byte pushed.

The register port is set to 32 bits or 8 bits wide by a parameter.
- On the 32-bit port, one read at offset 0 pops a byte. The byte comes back in bits 7:0 and its marker in bit 11.
- On the 8-bit port, a read at offset 0 pops the byte and copies its marker into a holding register. A read at offset 1 then returns the upper lane (bits 15:8 of the word), with the marker in lane bit 3. That second read is optional and never pops.

Two finite-state machines control the block. The arm machine has the states `ARM_IDLE` and `ARM_SET`. It moves IDLE→SET on `addr_done` without a push, and SET→IDLE on any push. The fill machine has the states `FILL_EMPTY`, `FILL_PART` and `FILL_FULL`. Its transitions follow the next occupancy: EMPTY→PART on a push, PART→FULL when the last slot fills, FULL→PART on a pop, PART→EMPTY when the last byte leaves, and EMPTY→FULL or FULL→EMPTY when the depth is 1.

Top module: `i2c_rxtag_fifo`

## Requirements
- R1: After reset, `rd_data`, `ovf_flag` and `udf_flag` are all zero and the queue is empty.
- R2: Data reads return the received bytes in the order they were pushed. Read data is registered: it appears in the cycle after the read strobe and holds until the next read.
- R3: The marker is 1 only for the first byte pushed after an `addr_done` pulse. A pulse in the same cycle as a push marks that byte. Every push, accepted or dropped, disarms the marker.
- R4: On the 32-bit port, a data read returns the byte in bits 7:0 and the marker in bit 11. Bits 10:8 and 31:12 are zero.
- R5: With the tag feature disabled (`TAG_EN`=0), every result bit above bit 7 reads zero, and so does the whole offset-1 lane.
- R6: On the 8-bit port, offset 0 returns the byte in bits 7:0 and pops it. Offset 1 returns the popped byte's marker in lane bit 3, with the other lane bits zero, and does not pop.
- R7: Skipping the offset-1 read does not disturb later data reads. Repeated offset-1 reads return the same marker until the next data read.
- R8: A push while the queue holds `DEPTH` bytes is dropped and sets the sticky `ovf_flag`. Stored bytes and their markers are kept.
- R9: A data read on an empty queue returns zero and does not pop. It sets the sticky `udf_flag` and clears the held marker.
- R10: A read at any offset other than the data offset (and, on the 8-bit port, the marker offset) returns zero and does not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Push strobe for one received byte |
| rx_byte | input | 8 | Received byte |
| addr_done | input | 1 | Address phase completed; arms the marker |
| rd_en | input | 1 | Register read strobe |
| rd_off | input | 2 | Register read byte offset |
| rd_data | output | BUS_W (32 or 8) | Registered read result |
| ovf_flag | output | 1 | Sticky: push dropped while full |
| udf_flag | output | 1 | Sticky: data read while empty |

## Verification
The hardest case to reach is the marker held across reads on the 8-bit port. It has to be shown that an offset-1 read reflects only the byte last popped, even when earlier offset-1 reads were skipped, repeated, or came after an empty-queue read. The bench drives wide, narrow and tag-disabled instances with identical stimulus. It builds sequences that arm the marker, mark a byte in the same cycle as the push, skip and repeat marker reads, and then fill past capacity. Underflow is left to the end because its flag is sticky.

// File: rtl/i2c_rxtag_pkg.sv
package i2c_rxtag_pkg;

    typedef struct packed {
        logic       mark;
        logic [7:0] dat;
    } rx_entry_t;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_PART,
        FILL_FULL
    } fill_state_e;

    typedef enum logic {
        ARM_IDLE,
        ARM_SET
    } arm_state_e;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_DATA,
        RD_MARK,
        RD_OTHER
    } rd_kind_e;

    localparam int MARK_BIT_WIDE = 11;
    localparam int MARK_BIT_LANE = 3;

endpackage

// File: rtl/i2c_rxtag_arm.sv
module i2c_rxtag_arm
    import i2c_rxtag_pkg::*;
#(
    parameter bit TAG_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_done,
    input  logic push,
    output logic mark_now,
    output logic armed
);

    arm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: if (addr_done && !push) state_d = ARM_SET;
            ARM_SET:  if (push)               state_d = ARM_IDLE;
            default:                          state_d = ARM_IDLE;
        endcase
    end

    always_comb begin
        armed    = (state_q == ARM_SET);
        mark_now = TAG_EN && ((state_q == ARM_SET) || addr_done);
    end

endmodule

// File: rtl/i2c_rxtag_store.sv
module i2c_rxtag_store
    import i2c_rxtag_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t push_ent,
    input  logic      pop_req,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic [CW-1:0] count,
    output logic      ovf
);

    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    rx_entry_t       mem [DEPTH];
    logic [PW-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]   cnt_q, cnt_d;
    fill_state_e     state_q, state_d;
    logic            push_ok, pop_ok, ovf_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && (state_q != FILL_FULL);
    assign pop_ok  = pop_req && (state_q != FILL_EMPTY);

    always_comb begin
        cnt_d = cnt_q;
        if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
        if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr_q] <= push_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr_q <= step(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= step(rd_ptr_q);
            cnt_q <= cnt_d;
            if (push && (state_q == FILL_FULL)) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: if (push_ok) state_d = (cnt_d == FULL_CNT) ? FILL_FULL : FILL_PART;
            FILL_PART: begin
                if (cnt_d == '0)           state_d = FILL_EMPTY;
                else if (cnt_d == FULL_CNT) state_d = FILL_FULL;
            end
            FILL_FULL:  if (pop_ok) state_d = (cnt_d == '0) ? FILL_EMPTY : FILL_PART;
            default:    state_d = FILL_EMPTY;
        endcase
    end

    always_comb begin
        head  = mem[rd_ptr_q];
        empty = (state_q == FILL_EMPTY);
        full  = (state_q == FILL_FULL);
        count = cnt_q;
        ovf   = ovf_q;
    end

endmodule

// File: rtl/i2c_rxtag_rdport.sv
module i2c_rxtag_rdport
    import i2c_rxtag_pkg::*;
#(
    parameter bit NARROW = 1'b0,
    parameter bit TAG_EN = 1'b1,
    localparam int BUS_W = NARROW ? 8 : 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [1:0]       rd_off,
    input  rx_entry_t        head,
    input  logic             empty,
    output logic             pop_req,
    output logic [BUS_W-1:0] rd_data,
    output logic             udf
);

    rd_kind_e         kind;
    logic             hold_q;
    logic             udf_q;
    logic [BUS_W-1:0] rd_q;
    logic [BUS_W-1:0] data_word;
    logic [BUS_W-1:0] mark_word;
    logic             head_mark;

    assign head_mark = TAG_EN && head.mark;

    always_comb begin
        if (!rd_en)                    kind = RD_NONE;
        else if (rd_off == 2'd0)       kind = RD_DATA;
        else if (NARROW && rd_off == 2'd1) kind = RD_MARK;
        else                           kind = RD_OTHER;
    end

    generate
        if (NARROW) begin : g_lane8
            always_comb begin
                data_word = head.dat;
                mark_word = '0;
                mark_word[MARK_BIT_LANE] = TAG_EN && hold_q;
            end
        end else begin : g_lane32
            always_comb begin
                data_word = {24'b0, head.dat};
                data_word[MARK_BIT_WIDE] = head_mark;
                mark_word = '0;
            end
        end
    endgenerate

    assign pop_req = (kind == RD_DATA) && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= '0;
            hold_q <= 1'b0;
            udf_q  <= 1'b0;
        end else begin
            unique case (kind)
                RD_DATA: begin
                    rd_q   <= empty ? '0 : data_word;
                    hold_q <= empty ? 1'b0 : head_mark;
                    if (empty) udf_q <= 1'b1;
                end
                RD_MARK:  rd_q <= mark_word;
                RD_OTHER: rd_q <= '0;
                default:  ;
            endcase
        end
    end

    assign rd_data = rd_q;
    assign udf     = udf_q;

endmodule

// File: rtl/i2c_rxtag_fifo.sv
module i2c_rxtag_fifo
    import i2c_rxtag_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter bit NARROW = 1'b0,
    parameter bit TAG_EN = 1'b1,
    localparam int BUS_W = NARROW ? 8 : 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             addr_done,
    input  logic             rd_en,
    input  logic [1:0]       rd_off,
    output logic [BUS_W-1:0] rd_data,
    output logic             ovf_flag,
    output logic             udf_flag
);

    logic          mark_now, armed;
    logic          pop_req, empty, full;
    logic [CW-1:0] fill_cnt;
    rx_entry_t     push_ent, head;

    assign push_ent.mark = mark_now;
    assign push_ent.dat  = rx_byte;

    i2c_rxtag_arm #(.TAG_EN(TAG_EN)) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_done(addr_done),
        .push     (rx_valid),
        .mark_now (mark_now),
        .armed    (armed)
    );

    i2c_rxtag_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rx_valid),
        .push_ent(push_ent),
        .pop_req (pop_req),
        .head    (head),
        .empty   (empty),
        .full    (full),
        .count   (fill_cnt),
        .ovf     (ovf_flag)
    );

    i2c_rxtag_rdport #(.NARROW(NARROW), .TAG_EN(TAG_EN)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .rd_off (rd_off),
        .head   (head),
        .empty  (empty),
        .pop_req(pop_req),
        .rd_data(rd_data),
        .udf    (udf_flag)
    );

endmodule

// File: rtl/i2c_rxtag_chk.sv
module i2c_rxtag_chk #(
    parameter int DEPTH = 8,
    parameter int BUS_W = 32,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             addr_done,
    input logic             rd_en,
    input logic [1:0]       rd_off,
    input logic [BUS_W-1:0] rd_data,
    input logic             ovf_flag,
    input logic             udf_flag,
    input logic [CW-1:0]    fill_cnt,
    input logic             armed
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        udf_flag |=> udf_flag);

    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fill_cnt == FULL_CNT && !(rd_en && rd_off == 2'd0))
        |=> (fill_cnt == FULL_CNT && ovf_flag));

    a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_off == 2'd0 && fill_cnt == '0)
        |=> (rd_data == '0 && udf_flag));

    // R6 and R10: a non-data offset never pops
    a_r10_off_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_off != 2'd0 && !rx_valid) |=> $stable(fill_cnt));

    a_r3_push_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !armed);

    a_r3_addr_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && !rx_valid) |=> armed);

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= FULL_CNT);

endmodule

bind i2c_rxtag_fifo i2c_rxtag_chk #(
    .DEPTH(DEPTH),
    .BUS_W(BUS_W),
    .CW   (CW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .addr_done(addr_done),
    .rd_en    (rd_en),
    .rd_off   (rd_off),
    .rd_data  (rd_data),
    .ovf_flag (ovf_flag),
    .udf_flag (udf_flag),
    .fill_cnt (fill_cnt),
    .armed    (armed)
);

// File: tb/i2c_rxtag_fifo_tb_top.sv
module i2c_rxtag_fifo_tb_top;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        addr_done = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_off = '0;

    logic [31:0] rd_w, rd_x;
    logic [7:0]  rd_n;
    logic        ovf_w, udf_w, ovf_n, udf_n, ovf_x, udf_x;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [8:0] mq[$];
    bit m_armed = 0, m_hold = 0, m_ovf = 0, m_udf = 0;

    always #5 clk = ~clk;

    i2c_rxtag_fifo #(.DEPTH(DEPTH), .NARROW(1'b0), .TAG_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .addr_done(addr_done), .rd_en(rd_en), .rd_off(rd_off),
        .rd_data(rd_w), .ovf_flag(ovf_w), .udf_flag(udf_w));

    i2c_rxtag_fifo #(.DEPTH(DEPTH), .NARROW(1'b1), .TAG_EN(1'b1)) dut_n (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .addr_done(addr_done), .rd_en(rd_en), .rd_off(rd_off),
        .rd_data(rd_n), .ovf_flag(ovf_n), .udf_flag(udf_n));

    i2c_rxtag_fifo #(.DEPTH(DEPTH), .NARROW(1'b0), .TAG_EN(1'b0)) dut_x (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .addr_done(addr_done), .rd_en(rd_en), .rd_off(rd_off),
        .rd_data(rd_x), .ovf_flag(ovf_x), .udf_flag(udf_x));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        check({ovf_w, ovf_n, ovf_x} == {3{m_ovf}}, req, "ovf flags",
              {29'b0, ovf_w, ovf_n, ovf_x}, {29'b0, {3{m_ovf}}});
        check({udf_w, udf_n, udf_x} == {3{m_udf}}, req, "udf flags",
              {29'b0, udf_w, udf_n, udf_x}, {29'b0, {3{m_udf}}});
    endtask

    task automatic strobe_addr();
        @(negedge clk);
        addr_done = 1'b1;
        @(negedge clk);
        addr_done = 1'b0;
        m_armed = 1;
    endtask

    task automatic push(input logic [7:0] b, input bit with_addr);
        bit t;
        @(negedge clk);
        rx_valid  = 1'b1;
        rx_byte   = b;
        addr_done = with_addr;
        @(negedge clk);
        rx_valid  = 1'b0;
        addr_done = 1'b0;
        t = m_armed | with_addr;
        m_armed = 0;
        if (mq.size() < DEPTH) mq.push_back({t, b});
        else m_ovf = 1;
    endtask

    task automatic do_read(input logic [1:0] off, input string req);
        logic [31:0] ew, ex;
        logic [7:0]  en;
        logic [8:0]  e;
        ew = '0; ex = '0; en = '0;
        if (off == 2'd0) begin
            if (mq.size() == 0) begin
                m_udf = 1; m_hold = 0;
            end else begin
                e = mq.pop_front();
                ew = {20'b0, e[8], 3'b0, e[7:0]};
                ex = {24'b0, e[7:0]};
                en = e[7:0];
                m_hold = e[8];
            end
        end else if (off == 2'd1) begin
            en = {4'b0, m_hold, 3'b0};
        end
        @(negedge clk);
        rd_en  = 1'b1;
        rd_off = off;
        @(negedge clk);
        rd_en  = 1'b0;
        rd_off = '0;
        check(rd_w == ew, req, "wide read", rd_w, ew);
        check(rd_n == en, req, "narrow read", {24'b0, rd_n}, {24'b0, en});
        check(rd_x == ex, "R5", "untagged read", rd_x, ex);
    endtask

    task automatic t_r1_reset();
        check(rd_w == '0 && rd_n == '0 && rd_x == '0, "R1", "rd_data at reset",
              rd_w | {24'b0, rd_n} | rd_x, 32'h0);
        check_flags("R1");
    endtask

    task automatic t_r2_order();
        push(8'h11, 0); push(8'h22, 0); push(8'h33, 0);
        do_read(2'd0, "R2"); do_read(2'd0, "R2"); do_read(2'd0, "R2");
        check_flags("R2");
    endtask

    task automatic t_r3_mark();
        strobe_addr();
        push(8'hA5, 0); push(8'h5A, 0);
        do_read(2'd0, "R4"); do_read(2'd1, "R6");
        do_read(2'd0, "R3"); do_read(2'd1, "R6");
        push(8'h77, 1);
        do_read(2'd0, "R3"); do_read(2'd1, "R3");
    endtask

    task automatic t_r7_skip();
        strobe_addr();
        push(8'hC1, 0); push(8'hC2, 0);
        strobe_addr();
        push(8'hC3, 0);
        do_read(2'd0, "R7"); do_read(2'd0, "R7");
        do_read(2'd1, "R7"); do_read(2'd1, "R7");
        do_read(2'd0, "R7"); do_read(2'd1, "R7"); do_read(2'd1, "R7");
    endtask

    task automatic t_r10_offsets();
        push(8'hF0, 1);
        do_read(2'd2, "R10"); do_read(2'd3, "R10"); do_read(2'd1, "R10");
        do_read(2'd0, "R10"); do_read(2'd1, "R10");
    endtask

    task automatic t_r8_overflow();
        strobe_addr();
        for (int i = 0; i < DEPTH + 1; i++) push(8'h40 + 8'(i), 0);
        check_flags("R8");
        for (int i = 0; i < DEPTH; i++) begin
            do_read(2'd0, "R8");
            do_read(2'd1, "R8");
        end
        check_flags("R8");
    endtask

    task automatic t_r9_underflow();
        do_read(2'd0, "R9");
        check_flags("R9");
        do_read(2'd1, "R9");
        push(8'h99, 0);
        do_read(2'd0, "R9");
        check_flags("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_r1_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_r1_reset();
        t_r2_order();
        t_r3_mark();
        t_r7_skip();
        t_r10_offsets();
        t_r8_overflow();
        t_r9_underflow();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule